// File: doc/BRIEF.md
# Write-Enable Latch and Block-Protect Register

This block guards writes into a byte-addressed serial memory. It holds two volatile latches, a write-enable latch and a register-write-enable latch, and five persistent bits: a two-bit watchdog interval select and a three-bit block-lock code. A serial slave front end decodes bus transfers and hands the block two kinds of event: a register-write strobe with one data byte, and an array-write request with a byte address. For each array request the block returns, one cycle later, either a grant pulse or a deny pulse.

Changing the persistent bits takes a fixed unlock sequence of register bytes. Byte 02h sets the write-enable latch. Byte 06h, accepted only once that latch is set, sets the register-write-enable latch. The next first byte of a register write is then loaded into the persistent fields. The block-lock code protects the top 1, 2, 4 or 8 pages of the array, the whole array, or nothing. The persistent fields are plain flip-flops. They are cleared only by the full initialisation reset and survive a power-cycle event, which clears just the volatile latches. The readable register byte is exported so the slave can return it when the control address is read.

Top module: `wprot_ctrl`

## Requirements
- R1: After `rst` the register byte reads 00h, `wd_sel_o` is 00, and neither `arr_grant_o` nor `arr_deny_o` is high.
- R2: A first register byte of 02h, taken while the register-write-enable latch is clear, sets the write-enable latch. The readable register holds it at bit 1.
- R3: A first register byte of 06h sets the register-write-enable latch (register bit 2) only while the write-enable latch is set. Otherwise the byte is ignored.
- R4: While both latches are set, the next first register byte loads its bits [7:6] into the watchdog field and its bits [5:3] into the lock code, clears the register-write-enable latch and keeps the write-enable latch. The bytes 02h, 06h, 02h therefore leave every persistent bit at 0.
- R5: While `wp_i` is high, a persistent update under R4 is rejected. The persistent bits and both latches keep their values.
- R6: A register byte with `reg_first_i` low changes nothing.
- R7: While the register-write-enable latch is clear, a first byte of 00h clears both latches. Any byte other than 00h, 02h and 06h is ignored.
- R8: An array request made while the write-enable latch is clear is denied.
- R9: Array requests are answered with a single-cycle grant or deny pulse on the cycle after the request. With 64-byte pages, lock code 000 protects nothing; 001, 010, 011 and 100 protect the top 1, 2, 4 and 8 pages; 101, 110 and 111 protect the whole array. An unprotected address with the write-enable latch set is granted.
- R10: An array request to a protected address clears the register-write-enable latch.
- R11: `por_i` clears both latches and leaves the persistent bits unchanged. It takes priority over any write in the same cycle.
- R12: `wd_sel_o` equals register bits [7:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full initialisation; clears latches and persistent bits |
| por_i | input | 1 | Power-cycle event; clears the volatile latches only |
| reg_wr_i | input | 1 | Register-write byte strobe |
| reg_first_i | input | 1 | High when the strobed byte is the first data byte of its transfer |
| reg_data_i | input | 8 | Register data byte |
| arr_req_i | input | 1 | Array-write request strobe |
| arr_addr_i | input | ADDR_W | Byte address of the array write |
| wp_i | input | 1 | Write-protect pin, active high |
| arr_grant_o | output | 1 | Array write allowed, one cycle after the request |
| arr_deny_o | output | 1 | Array write refused, one cycle after the request |
| wd_sel_o | output | 2 | Watchdog interval select |
| reg_rd_o | output | 8 | Readable register byte: [7:6] watchdog, [5:3] lock code, [2] register-write-enable, [1] write-enable, [0] zero |

## Verification
A wrong latch state appears on `reg_rd_o` at the clock edge that follows the offending byte. The error also surfaces in the grant and deny pulse of the next array request, one cycle after that request. A wrong lock code, or an off-by-one page boundary, shows only when an address on either side of the boundary is tried. For that reason every lock code is exercised with the last unprotected address and the first protected one. Rejections caused by the write-protect pin, by a missing latch, and by non-first bytes are checked by reading the register back on the cycle right after the ignored byte.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam int BYTE_W = 8;
  localparam int WD_W   = 2;
  localparam int LOCK_W = 3;
  localparam int CODES  = 1 << LOCK_W;

  // Command bytes of the unlock sequence
  localparam logic [BYTE_W-1:0] CMD_CLR      = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_SET_WEL  = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_SET_RWEL = 8'h06;

  // Field positions in the register byte
  localparam int WD_LSB   = 6;
  localparam int LOCK_LSB = 3;
  localparam int RWEL_BIT = 2;
  localparam int WEL_BIT  = 1;

  typedef struct packed {
    logic [WD_W-1:0]   wd;
    logic [LOCK_W-1:0] lock;
  } persist_t;

  // Number of top pages a lock code protects
  function automatic int span_of(input int code, input int num_pages);
    case (code)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      3:       return 4;
      4:       return 8;
      default: return num_pages;
    endcase
  endfunction

endpackage

// File: rtl/wprot_latch.sv
module wprot_latch
  import wprot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              por_i,
  input  logic              reg_wr_i,
  input  logic              reg_first_i,
  input  logic [BYTE_W-1:0] reg_data_i,
  input  logic              wp_i,
  input  logic              clr_rwel_i,
  output logic              wel_o,
  output logic              rwel_o,
  output persist_t          persist_o
);

  logic     wel_q, rwel_q;
  persist_t nv_q;
  logic     take_byte;

  assign take_byte = reg_wr_i & reg_first_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
      nv_q   <= '0;
    end else if (por_i) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else begin
      if (take_byte) begin
        if (wel_q && rwel_q) begin
          if (!wp_i) begin
            nv_q.wd   <= reg_data_i[WD_LSB +: WD_W];
            nv_q.lock <= reg_data_i[LOCK_LSB +: LOCK_W];
            rwel_q    <= 1'b0;
          end
        end else begin
          case (reg_data_i)
            CMD_SET_WEL:  wel_q <= 1'b1;
            CMD_SET_RWEL: if (wel_q) rwel_q <= 1'b1;
            CMD_CLR: begin
              wel_q  <= 1'b0;
              rwel_q <= 1'b0;
            end
            default: ;
          endcase
        end
      end
      if (clr_rwel_i) rwel_q <= 1'b0;
    end
  end

  assign wel_o     = wel_q;
  assign rwel_o    = rwel_q;
  assign persist_o = nv_q;

endmodule

// File: rtl/wprot_zone.sv
module wprot_zone
  import wprot_pkg::*;
#(
  parameter int PG_W = 6
) (
  input  logic [PG_W-1:0]   page_i,
  input  logic [LOCK_W-1:0] lock_i,
  output logic              prot_o
);

  localparam int NUM_PAGES = 1 << PG_W;

  logic [CODES-1:0] hit;

  for (genvar g = 0; g < CODES; g++) begin : g_code
    localparam int SPAN = span_of(g, NUM_PAGES);
    if (SPAN == 0) begin : g_none
      assign hit[g] = 1'b0;
    end else if (SPAN >= NUM_PAGES) begin : g_all
      assign hit[g] = 1'b1;
    end else begin : g_top
      assign hit[g] = (page_i >= PG_W'(NUM_PAGES - SPAN));
    end
  end

  assign prot_o = hit[lock_i];

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic wel_i,
  input  logic prot_i,
  output logic grant_o,
  output logic deny_o
);

  logic ok;
  assign ok = wel_i & ~prot_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
    end else begin
      grant_o <= req_i & ok;
      deny_o  <= req_i & ~ok;
    end
  end

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_i,
  input  logic              reg_wr_i,
  input  logic              reg_first_i,
  input  logic [7:0]        reg_data_i,
  input  logic              arr_req_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic              wp_i,
  output logic              arr_grant_o,
  output logic              arr_deny_o,
  output logic [1:0]        wd_sel_o,
  output logic [7:0]        reg_rd_o
);

  localparam int PG_W = ADDR_W - PAGE_W;

  logic     wel, rwel, prot, clr_rwel;
  persist_t nv;
  logic     unused_low;

  assign unused_low = ^arr_addr_i[PAGE_W-1:0];

  wprot_zone #(.PG_W(PG_W)) u_zone (
    .page_i (arr_addr_i[ADDR_W-1:PAGE_W]),
    .lock_i (nv.lock),
    .prot_o (prot)
  );

  assign clr_rwel = arr_req_i & prot;

  wprot_latch u_latch (
    .clk         (clk),
    .rst         (rst),
    .por_i       (por_i),
    .reg_wr_i    (reg_wr_i),
    .reg_first_i (reg_first_i),
    .reg_data_i  (reg_data_i),
    .wp_i        (wp_i),
    .clr_rwel_i  (clr_rwel),
    .wel_o       (wel),
    .rwel_o      (rwel),
    .persist_o   (nv)
  );

  wprot_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .req_i   (arr_req_i),
    .wel_i   (wel),
    .prot_i  (prot),
    .grant_o (arr_grant_o),
    .deny_o  (arr_deny_o)
  );

  assign reg_rd_o = {nv.wd, nv.lock, rwel, wel, 1'b0};
  assign wd_sel_o = nv.wd;

endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              por_i,
  input logic              reg_wr_i,
  input logic              reg_first_i,
  input logic [7:0]        reg_data_i,
  input logic              arr_req_i,
  input logic [ADDR_W-1:0] arr_addr_i,
  input logic              wp_i,
  input logic              arr_grant_o,
  input logic              arr_deny_o,
  input logic [1:0]        wd_sel_o,
  input logic [7:0]        reg_rd_o
);

  // R9
  grant_deny_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arr_grant_o, arr_deny_o}));

  // R9
  no_pulse_without_req_chk: assert property (@(posedge clk) disable iff (rst)
    !arr_req_i |=> !arr_grant_o && !arr_deny_o);

  // R8
  deny_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
    arr_req_i && !reg_rd_o[1] |=> arr_deny_o);

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_i && reg_first_i && reg_data_i == 8'h02 && !reg_rd_o[2] && !por_i
    |=> reg_rd_o[1]);

  // R5
  wp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_i && wp_i |=> reg_rd_o[7:3] == $past(reg_rd_o[7:3]));

  // R6
  non_first_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_i && !reg_first_i && !arr_req_i && !por_i
    |=> reg_rd_o == $past(reg_rd_o));

  // R11
  por_keep_chk: assert property (@(posedge clk) disable iff (rst)
    por_i |=> reg_rd_o[2:1] == 2'b00 && reg_rd_o[7:3] == $past(reg_rd_o[7:3]));

  // R12
  wd_match_chk: assert property (@(posedge clk) disable iff (rst)
    wd_sel_o == reg_rd_o[7:6]);

endmodule

bind wprot_ctrl wprot_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .por_i       (por_i),
  .reg_wr_i    (reg_wr_i),
  .reg_first_i (reg_first_i),
  .reg_data_i  (reg_data_i),
  .arr_req_i   (arr_req_i),
  .arr_addr_i  (arr_addr_i),
  .wp_i        (wp_i),
  .arr_grant_o (arr_grant_o),
  .arr_deny_o  (arr_deny_o),
  .wd_sel_o    (wd_sel_o),
  .reg_rd_o    (reg_rd_o)
);

// File: tb/sim_wprot_ctrl.sv
module sim_wprot_ctrl;

  localparam int CLK_PER = 10;
  localparam int ADDR_W  = 12;

  localparam logic [1:0] OP_REG = 2'd0, OP_ARR = 2'd1, OP_POR = 2'd2;
  localparam logic [1:0] GD_NONE = 2'b00, GD_GRANT = 2'b10, GD_DENY = 2'b01;

  typedef struct packed {
    logic [1:0]  op;
    logic        first;
    logic        wp;
    logic [7:0]  data;
    logic [11:0] addr;
    logic [7:0]  exp_reg;
    logic [1:0]  exp_gd;
  } vec_t;

  function automatic vec_t mk(input logic [1:0] op, input logic first, input logic wp,
                              input logic [7:0] data, input logic [11:0] addr,
                              input logic [7:0] exp_reg, input logic [1:0] exp_gd);
    vec_t v;
    v.op = op; v.first = first; v.wp = wp; v.data = data; v.addr = addr;
    v.exp_reg = exp_reg; v.exp_gd = exp_gd;
    return v;
  endfunction

  localparam int NV = 42;
  localparam vec_t TBL [NV] = '{
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'h00, GD_NONE),  // 0  R3 06h without WEL ignored
    mk(OP_ARR, 0, 0, 8'h00, 12'h000, 8'h00, GD_DENY),  // 1  R8
    mk(OP_REG, 1, 0, 8'h02, 12'h000, 8'h02, GD_NONE),  // 2  R2
    mk(OP_ARR, 0, 0, 8'h00, 12'h000, 8'h02, GD_GRANT), // 3  R9 code 000
    mk(OP_REG, 1, 0, 8'h55, 12'h000, 8'h02, GD_NONE),  // 4  R7 other byte ignored
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'h06, GD_NONE),  // 5  R3
    mk(OP_REG, 0, 0, 8'hFF, 12'h000, 8'h06, GD_NONE),  // 6  R6
    mk(OP_REG, 1, 1, 8'hE8, 12'h000, 8'h06, GD_NONE),  // 7  R5
    mk(OP_REG, 1, 0, 8'hE8, 12'h000, 8'hEA, GD_NONE),  // 8  R4 load
    mk(OP_ARR, 0, 0, 8'h00, 12'h000, 8'hEA, GD_DENY),  // 9  R9 code 101
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'hEE, GD_NONE),  // 10
    mk(OP_REG, 1, 0, 8'h02, 12'h000, 8'h02, GD_NONE),  // 11 R4 02,06,02 clears
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'h06, GD_NONE),  // 12
    mk(OP_REG, 1, 0, 8'h08, 12'h000, 8'h0A, GD_NONE),  // 13 code 001
    mk(OP_ARR, 0, 0, 8'h00, 12'hFBF, 8'h0A, GD_GRANT), // 14 R9
    mk(OP_ARR, 0, 0, 8'h00, 12'hFC0, 8'h0A, GD_DENY),  // 15 R9
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'h0E, GD_NONE),  // 16
    mk(OP_ARR, 0, 0, 8'h00, 12'hFFF, 8'h0A, GD_DENY),  // 17 R10
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'h0E, GD_NONE),  // 18
    mk(OP_REG, 1, 0, 8'h10, 12'h000, 8'h12, GD_NONE),  // 19 code 010
    mk(OP_ARR, 0, 0, 8'h00, 12'hF7F, 8'h12, GD_GRANT), // 20 R9
    mk(OP_ARR, 0, 0, 8'h00, 12'hF80, 8'h12, GD_DENY),  // 21 R9
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'h16, GD_NONE),  // 22
    mk(OP_REG, 1, 0, 8'h18, 12'h000, 8'h1A, GD_NONE),  // 23 code 011
    mk(OP_ARR, 0, 0, 8'h00, 12'hEFF, 8'h1A, GD_GRANT), // 24 R9
    mk(OP_ARR, 0, 0, 8'h00, 12'hF00, 8'h1A, GD_DENY),  // 25 R9
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'h1E, GD_NONE),  // 26
    mk(OP_REG, 1, 0, 8'h20, 12'h000, 8'h22, GD_NONE),  // 27 code 100
    mk(OP_ARR, 0, 0, 8'h00, 12'hDFF, 8'h22, GD_GRANT), // 28 R9
    mk(OP_ARR, 0, 0, 8'h00, 12'hE00, 8'h22, GD_DENY),  // 29 R9
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'h26, GD_NONE),  // 30
    mk(OP_REG, 1, 0, 8'h30, 12'h000, 8'h32, GD_NONE),  // 31 code 110
    mk(OP_ARR, 0, 0, 8'h00, 12'h000, 8'h32, GD_DENY),  // 32 R9 110 is all
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'h36, GD_NONE),  // 33
    mk(OP_REG, 1, 0, 8'h00, 12'h000, 8'h02, GD_NONE),  // 34 R4 00h loads when unlocked
    mk(OP_REG, 1, 0, 8'h00, 12'h000, 8'h00, GD_NONE),  // 35 R7 00h clears latches
    mk(OP_REG, 1, 0, 8'h02, 12'h000, 8'h02, GD_NONE),  // 36
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'h06, GD_NONE),  // 37
    mk(OP_REG, 1, 0, 8'h48, 12'h000, 8'h4A, GD_NONE),  // 38 wd=01 code 001
    mk(OP_REG, 1, 0, 8'h06, 12'h000, 8'h4E, GD_NONE),  // 39
    mk(OP_POR, 1, 0, 8'h02, 12'h000, 8'h48, GD_NONE),  // 40 R11 (with a write the same cycle)
    mk(OP_ARR, 0, 0, 8'h00, 12'h000, 8'h48, GD_DENY)   // 41 R8 after power cycle
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              por_i = 1'b0;
  logic              reg_wr_i = 1'b0;
  logic              reg_first_i = 1'b0;
  logic [7:0]        reg_data_i = 8'h00;
  logic              arr_req_i = 1'b0;
  logic [ADDR_W-1:0] arr_addr_i = '0;
  logic              wp_i = 1'b0;
  logic              arr_grant_o, arr_deny_o;
  logic [1:0]        wd_sel_o;
  logic [7:0]        reg_rd_o;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  always #(CLK_PER/2) clk = ~clk;

  wprot_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(6)) u0 (
    .clk(clk), .rst(rst), .por_i(por_i), .reg_wr_i(reg_wr_i),
    .reg_first_i(reg_first_i), .reg_data_i(reg_data_i), .arr_req_i(arr_req_i),
    .arr_addr_i(arr_addr_i), .wp_i(wp_i), .arr_grant_o(arr_grant_o),
    .arr_deny_o(arr_deny_o), .wd_sel_o(wd_sel_o), .reg_rd_o(reg_rd_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    por_i = 0; reg_wr_i = 0; reg_first_i = 0; reg_data_i = 8'h00;
    arr_req_i = 0; arr_addr_i = '0; wp_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 reg", reg_rd_o, 8'h00);
    check("R1 wd", {6'b0, wd_sel_o}, 8'h00);
    check("R1 pulses", {6'b0, arr_grant_o, arr_deny_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = TBL[i];
      por_i       = (v.op == OP_POR);
      reg_wr_i    = (v.op == OP_REG) || (v.op == OP_POR);
      reg_first_i = v.first;
      reg_data_i  = v.data;
      arr_req_i   = (v.op == OP_ARR);
      arr_addr_i  = v.addr;
      wp_i        = v.wp;
      @(negedge clk);
      idle();
      tag = $sformatf("vec%0d reg", i);
      check(tag, reg_rd_o, v.exp_reg);
      tag = $sformatf("vec%0d R9 grant/deny", i);
      check(tag, {6'b0, arr_grant_o, arr_deny_o}, {6'b0, v.exp_gd});
    end

    // R12 watchdog select follows the stored field (01 loaded in vec38)
    check("R12 wd", {6'b0, wd_sel_o}, 8'h01);
    // R9 pulse lasts one cycle
    @(negedge clk);
    check("R9 pulse end", {6'b0, arr_grant_o, arr_deny_o}, 8'h00);

    // R1 full reset clears persistent bits as well
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 reg after rst", reg_rd_o, 8'h00);
    check("R1 wd after rst", {6'b0, wd_sel_o}, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule